// File: doc/BRIEF.md
# Sampled Pushbutton Debouncer with Edge Pulses

This block cleans the level of a bouncing mechanical pushbutton inside one system clock domain. The raw button is handled only as data: it passes through a chain of synchronizer flops, and a prescaler then produces a slow sample strobe, about once per millisecond by default. On each strobe the synchronized level shifts into a short history register. A consensus stage changes the debounced level only when the whole history agrees. Under this rule a short bounce cannot move the output.

The debounced level goes high only when every history bit is one. It goes low only when every history bit is zero. A mixed history leaves the level where it was, so the output has hysteresis. An edge stage turns each accepted press into a pulse one system clock wide. It can also produce a matching pulse on each accepted release, chosen by a parameter. The divisor of the prescaler is computed from the clock frequency and the sample period. The history depth and the number of synchronizer stages are also parameters.

Top module: `btn_debounce`

## Requirements
- R1: With reset deasserted and the raw button held low, `btn_level`, `btn_press` and `btn_release` stay 0.
- R2: The history register shifts only in a cycle in which the internal sample strobe is high. The strobe is high once every TICK_DIV system clocks, where TICK_DIV = CLK_FREQ_HZ * SAMPLE_PERIOD_US / 1,000,000, with a minimum of 2.
- R3: `btn_level` becomes 1 only after all HIST_DEPTH samples are 1. A button held high for (HIST_DEPTH+2)*TICK_DIV + SYNC_STAGES + 4 clocks drives the level to 1.
- R4: `btn_level` becomes 0 only after all HIST_DEPTH samples are 0. A button held low for the same time drives the level to 0.
- R5: A history that holds both ones and zeros leaves `btn_level` unchanged. A high or low glitch shorter than 2*TICK_DIV clocks, or a burst of such glitches, therefore changes neither the level nor either pulse output.
- R6: `btn_press` is 1 for exactly one clock, in the clock cycle right after `btn_level` goes from 0 to 1, and at no other time.
- R7: When RELEASE_EN is 1, `btn_release` is 1 for exactly one clock, in the clock cycle right after `btn_level` goes from 1 to 0. When RELEASE_EN is 0, `btn_release` is always 0.
- R8: A synchronous reset (`rst` high) clears the synchronizer, the prescaler, the history, the level and both pulses to 0 by the next clock. No release pulse follows from this. If the button is still held after reset, a fresh press pulse is produced.
- R9: `btn_level` changes only two clocks after a sample strobe, that is, one clock after the history shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all registers use it |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw mechanical button level, asynchronous, 1 = pressed |
| btn_level | output | 1 | Debounced button level |
| btn_press | output | 1 | One-clock pulse after each accepted press |
| btn_release | output | 1 | One-clock pulse after each accepted release (0 when RELEASE_EN is 0) |

## Verification
The hardest case to reach from the ports is a history that is mixed but already leans toward a change of level. Here the level must hold on hysteresis alone while later strobes still carry leftover samples of a glitch. The stimulus creates this with short glitches and bursts, each kept below two strobe periods, placed right after a settled press and right after a settled release. The bench then checks that the level stays put and that no pulse appears. A second case is a reset applied while the button is held down. That case must give no release pulse and then one fresh press pulse, which shows that the history really was cleared.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

  // Result of the consensus over the sample history.
  typedef enum logic [1:0] {
    VOTE_MIXED = 2'd0,
    VOTE_ZEROS = 2'd1,
    VOTE_ONES  = 2'd2
  } vote_e;

  // Clocks between two sample strobes, never less than 2.
  function automatic int unsigned tick_divisor(input int unsigned clk_hz,
                                               input int unsigned period_us);
    longint unsigned cycles;
    cycles = (longint'(clk_hz) * longint'(period_us)) / 64'd1000000;
    if (cycles < 64'd2) cycles = 64'd2;
    return int'(cycles);
  endfunction

  // Bits needed to count 0 .. n-1.
  function automatic int unsigned count_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Consensus across a history word, packed into a 32-bit carrier.
  function automatic vote_e consensus(input logic [31:0] bits, input int unsigned depth);
    logic [31:0] mask;
    mask = (depth >= 32) ? 32'hFFFF_FFFF : ((32'd1 << depth) - 32'd1);
    if ((bits & mask) == mask) return VOTE_ONES;
    if ((bits & mask) == 32'd0) return VOTE_ZEROS;
    return VOTE_MIXED;
  endfunction

endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

  // R8: reset empties the synchronizer by the next clock
  p_sync_reset_r8: assert property (@(posedge clk) rst |=> (q_sync == 1'b0));
endmodule

// File: rtl/dbn_prescaler.sv
module dbn_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = dbn_pkg::count_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2: the strobe never lasts two clocks in a row (DIV is at least 2)
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
endmodule

// File: rtl/dbn_history.sv
module dbn_history
  import dbn_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sample,
  output logic level
);
  logic [DEPTH-1:0] hist;
  logic [DEPTH-1:0] hist_nxt;
  vote_e            vote;

  generate
    if (DEPTH == 1) begin : g_d1
      assign hist_nxt = sample;
    end else begin : g_dn
      assign hist_nxt = {hist[DEPTH-2:0], sample};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       hist <= '0;
    else if (tick) hist <= hist_nxt;
  end

  always_comb begin
    vote = consensus(32'(hist), DEPTH);
  end

  always_ff @(posedge clk) begin
    if (rst) level <= 1'b0;
    else begin
      case (vote)
        VOTE_ONES:  level <= 1'b1;
        VOTE_ZEROS: level <= 1'b0;
        default:    level <= level;
      endcase
    end
  end

  // R2: the history is frozen between strobes
  p_hist_hold_r2: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(hist));
  // R3: the level rises only out of a full-ones history
  p_rise_all_ones_r3: assert property (@(posedge clk) disable iff (rst) $rose(level) |-> ($past(hist) == {DEPTH{1'b1}}));
  // R4: the level falls only out of a full-zeros history
  p_fall_all_zeros_r4: assert property (@(posedge clk) disable iff (rst) $fell(level) |-> ($past(hist) == '0));
  // R5: a mixed history keeps the level
  p_mixed_hold_r5: assert property (@(posedge clk) disable iff (rst) (hist != '0 && hist != {DEPTH{1'b1}}) |=> $stable(level));
  // R9: a level change is always two clocks behind a strobe
  p_level_after_tick_r9: assert property (@(posedge clk) disable iff (rst) !$stable(level) |-> $past(tick, 2));
  // R8: reset clears history and level
  p_hist_reset_r8: assert property (@(posedge clk) rst |=> (hist == '0 && level == 1'b0));
endmodule

// File: rtl/dbn_edges.sv
module dbn_edges #(
  parameter bit RELEASE_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic press,
  output logic release_p
);
  logic level_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_prev <= 1'b0;
      press      <= 1'b0;
    end else begin
      level_prev <= level;
      press      <= level & ~level_prev;
    end
  end

  generate
    if (RELEASE_EN) begin : g_rel
      always_ff @(posedge clk) begin
        if (rst) release_p <= 1'b0;
        else     release_p <= ~level & level_prev;
      end
      // R7: a fall of the level gives a release pulse next clock, one clock wide
      p_release_follows_r7: assert property (@(posedge clk) disable iff (rst) $fell(level) |=> release_p);
      p_release_width_r7: assert property (@(posedge clk) disable iff (rst) release_p |=> !release_p);
    end else begin : g_norel
      assign release_p = 1'b0;
    end
  endgenerate

  // R6: a rise of the level gives a press pulse next clock, one clock wide
  p_press_follows_r6: assert property (@(posedge clk) disable iff (rst) $rose(level) |=> press);
  p_press_width_r6: assert property (@(posedge clk) disable iff (rst) press |=> !press);
  // R8: reset clears the pulses
  p_pulse_reset_r8: assert property (@(posedge clk) rst |=> (!press && !release_p));
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned CLK_FREQ_HZ      = 50_000_000,
  parameter int unsigned SAMPLE_PERIOD_US = 1000,
  parameter int unsigned HIST_DEPTH       = 4,
  parameter int unsigned SYNC_STAGES      = 2,
  parameter bit          RELEASE_EN       = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_level,
  output logic btn_press,
  output logic btn_release
);
  localparam int unsigned TICK_DIV = dbn_pkg::tick_divisor(CLK_FREQ_HZ, SAMPLE_PERIOD_US);

  // Named internal events, visible to the assertions
  logic btn_synced;
  logic sample_tick;

  dbn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (btn_raw),
    .q_sync  (btn_synced)
  );

  dbn_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .tick (sample_tick)
  );

  dbn_history #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk    (clk),
    .rst    (rst),
    .tick   (sample_tick),
    .sample (btn_synced),
    .level  (btn_level)
  );

  dbn_edges #(.RELEASE_EN(RELEASE_EN)) u_edges (
    .clk       (clk),
    .rst       (rst),
    .level     (btn_level),
    .press     (btn_press),
    .release_p (btn_release)
  );

  // R6: press and release never coincide
  p_pulse_exclusive_r6: assert property (@(posedge clk) disable iff (rst) !(btn_press && btn_release));
endmodule

// File: tb/btn_debounce_test.sv
module btn_debounce_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  typedef struct packed {
    logic        raw;
    logic [15:0] hold;
    logic        lvl;
    logic [7:0]  dp;
    logic [7:0]  dr;
    logic [7:0]  req;
  } vec_t;

  // Strobe every 8 clocks (8 MHz, 1 us); glitches stay below 16 clocks.
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'd60, 1'b0, 8'd0, 8'd0, 8'd1},  // R1 idle low
    '{1'b1, 16'd60, 1'b1, 8'd1, 8'd0, 8'd3},  // R3 steady press
    '{1'b0, 16'd10, 1'b1, 8'd0, 8'd0, 8'd5},  // R5 low glitch while pressed
    '{1'b1, 16'd60, 1'b1, 8'd0, 8'd0, 8'd5},
    '{1'b0, 16'd60, 1'b0, 8'd0, 8'd1, 8'd4},  // R4 steady release
    '{1'b1, 16'd12, 1'b0, 8'd0, 8'd0, 8'd5},  // R5 high glitch while released
    '{1'b0, 16'd60, 1'b0, 8'd0, 8'd0, 8'd5},
    '{1'b1, 16'd5,  1'b0, 8'd0, 8'd0, 8'd5},  // bounce burst into press
    '{1'b0, 16'd3,  1'b0, 8'd0, 8'd0, 8'd5},
    '{1'b1, 16'd6,  1'b0, 8'd0, 8'd0, 8'd5},
    '{1'b0, 16'd4,  1'b0, 8'd0, 8'd0, 8'd5},
    '{1'b1, 16'd60, 1'b1, 8'd1, 8'd0, 8'd6},  // R6 one press after burst
    '{1'b0, 16'd4,  1'b1, 8'd0, 8'd0, 8'd5},  // bounce burst into release
    '{1'b1, 16'd3,  1'b1, 8'd0, 8'd0, 8'd5},
    '{1'b0, 16'd60, 1'b0, 8'd0, 8'd1, 8'd7}   // R7 one release after burst
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;
  logic btn_level, btn_press, btn_release;
  logic nr_level, nr_press, nr_release;

  int checks = 0;
  int failures = 0;
  int press_cnt = 0;
  int rel_cnt = 0;
  bit done = 1'b0;
  logic lvl_d1 = 1'b0;
  logic lvl_d2 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btn_debounce #(.CLK_FREQ_HZ(8_000_000), .SAMPLE_PERIOD_US(1), .HIST_DEPTH(DEPTH),
                 .SYNC_STAGES(2), .RELEASE_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .btn_raw(btn_raw),
    .btn_level(btn_level), .btn_press(btn_press), .btn_release(btn_release));

  btn_debounce #(.CLK_FREQ_HZ(8_000_000), .SAMPLE_PERIOD_US(1), .HIST_DEPTH(DEPTH),
                 .SYNC_STAGES(2), .RELEASE_EN(1'b0)) uut_norel (
    .clk(clk), .rst(rst), .btn_raw(btn_raw),
    .btn_level(nr_level), .btn_press(nr_press), .btn_release(nr_release));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Pulse monitor, sampled at the falling edge.
  always @(negedge clk) begin
    if (press_cnt >= 0) begin
      if (btn_press)   press_cnt++;
      if (btn_release) rel_cnt++;
    end
    if (rst) begin
      lvl_d1 = 1'b0;
      lvl_d2 = 1'b0;
    end else begin
      check("R6", "press vs level rise", btn_press, lvl_d1 & ~lvl_d2);
      check("R7", "release vs level fall", btn_release, ~lvl_d1 & lvl_d2);
      check("R7", "disabled release", nr_release, 0);
      check("R6", "no-release variant press", nr_press, btn_press);
      lvl_d2 = lvl_d1;
      lvl_d1 = btn_level;
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int p0, r0;
    p0 = press_cnt;
    r0 = rel_cnt;
    btn_raw = v.raw;
    wait_cycles(int'(v.hold));
    check($sformatf("R%0d", v.req), "level", btn_level, v.lvl);
    check($sformatf("R%0d", v.req), "press count", press_cnt - p0, v.dp);
    check($sformatf("R%0d", v.req), "release count", rel_cnt - r0, v.dr);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int p0, r0;
    // R1 / R8: reset state, button already high during reset
    btn_raw = 1'b1;
    wait_cycles(20);
    check("R8", "level in reset", btn_level, 0);
    check("R8", "press in reset", btn_press, 0);
    check("R8", "release in reset", btn_release, 0);
    check("R1", "press count in reset", press_cnt, 0);
    btn_raw = 1'b0;
    rst = 1'b0;

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R8: reset while the button is held
    btn_raw = 1'b1;
    wait_cycles(60);
    check("R3", "level before reset", btn_level, 1);
    p0 = press_cnt;
    r0 = rel_cnt;
    rst = 1'b1;
    wait_cycles(3);
    check("R8", "level cleared", btn_level, 0);
    check("R8", "press cleared", btn_press, 0);
    check("R8", "no release from reset", rel_cnt - r0, 0);
    rst = 1'b0;
    wait_cycles(60);
    check("R8", "level after reset", btn_level, 1);
    check("R8", "fresh press after reset", press_cnt - p0, 1);

    // R7: release on the disabled variant stays low (monitor), level follows
    btn_raw = 1'b0;
    wait_cycles(60);
    check("R7", "variant level low", nr_level, 0);
    check("R4", "level low", btn_level, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule